// File: doc/BRIEF.md
# Dual-Rate Serial Tick Generator

This block derives two single-cycle rate enables, one for a serial transmitter and one for a serial receiver, from the system bus clock. No divided clock is produced. Every downstream flop stays on the bus clock and advances only when its tick is high.

The first stage is a shared prescaler with four non-binary factors. Its output enable feeds two independent power-of-two stages, one per direction. The receive direction then passes through an optional 8-bit extra divider of its own.

Software programs the block through one write port that reaches two 8-bit registers: a rate register and an extra receive divider register. Any write to either register restarts every divider stage from phase zero.

Top module: `dual_rate_tick_gen`

## Requirements
- R1: A write with `wr_en`=1 and `wr_sel`=0 loads `wr_data` into the rate register. A write with `wr_sel`=1 loads the extra receive divider register. Rate register fields: bits 7:6 are the prescaler select, bits 5:3 the transmit exponent, bits 2:0 the receive exponent.
- R2: Prescaler select 00, 01, 10 and 11 divides the bus clock by 1, 3, 4 and 13 respectively.
- R3: The transmit tick period in bus clocks is the prescaler factor times 2 to the power of the transmit exponent (000 gives 1, 111 gives 128).
- R4: The receive exponent gives a factor of 2 to its power, independent of the transmit exponent. The conventional receive period is the prescaler factor times that factor.
- R5: When the extra receive divider register is 0, the receive period is the conventional one. A value N from 1 to 255 multiplies the conventional receive period by N.
- R6: Both registers reset to 00h, so after reset both ticks are asserted on every bus clock.
- R7: Each tick is one bus clock wide. With a period above 1, a tick is never high on two consecutive cycles.
- R8: A write to either register clears every divider counter. With a resulting period D, the first tick after the write appears D-1 cycles after the cycle that follows the write edge, and every D cycles after that.
- R9: A period of 1 asserts the tick on every bus clock.
- R10: Writing the extra receive divider register leaves the transmit period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the rate register, 1 selects the extra receive divider |
| wr_data | input | 8 | Write data |
| tx_tick | output | 1 | Transmit rate enable, one cycle wide |
| rx_tick | output | 1 | Receive rate enable, one cycle wide |

## Verification
A counter stuck at a wrong value shows up at the ports within one programmed period. The first tick after a write then arrives early or late, or the spacing between ticks drifts, so the bench measures both the first-tick offset and the number of ticks over three full periods. A decode error in the prescaler or exponent changes the period on every case that uses that code, which makes it visible from the first tick. A missing clear on write shows up as a first tick at a residual phase instead of at D-1.

// File: rtl/baudgen_pkg.sv
// Package: shared widths and the prescaler factor decode for the tick generator.
// Assumes an 8-bit register file, with field positions fixed by the rate register layout.
package baudgen_pkg;
    localparam int REG_W    = 8;
    localparam int PRE_SELW = 2;
    localparam int EXP_W    = 3;
    localparam int PRE_CW   = 4;

    // Maps the prescaler select code to its division factor.
    function automatic logic [PRE_CW-1:0] pre_factor(input logic [PRE_SELW-1:0] s);
        case (s)
            2'b00:   pre_factor = 4'd1;
            2'b01:   pre_factor = 4'd3;
            2'b10:   pre_factor = 4'd4;
            default: pre_factor = 4'd13;
        endcase
    endfunction
endpackage

// File: rtl/pre_divider.sv
// Shared first stage: emits one enable pulse every 1, 3, 4 or 13 bus clocks.
// Assumes clr is a single-cycle restart request. Factor 1 yields a tick every cycle.
module pre_divider
    import baudgen_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [PRE_SELW-1:0] sel,
    output logic                tick
);
    logic [PRE_CW-1:0] cnt_q;
    logic [PRE_CW-1:0] lim;

    // Terminal count is the decoded factor minus one.
    always_comb begin
        lim  = pre_factor(sel) - 4'd1;
        tick = (cnt_q == lim);
    end

    // Free-running modulo counter, restarted on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pow2_divider.sv
// Power-of-two stage: passes one of every 2**sel input enables.
// Assumes en_in is a single-cycle enable. sel = 0 passes every enable straight through.
module pow2_divider #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // Terminal count is 2**sel - 1, built as a thermometer mask.
    always_comb begin
        lim = '0;
        for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(sel));
        tick = en_in && (cnt_q == lim);
    end

    // Counts input enables and wraps on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else if (en_in)     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ext_divider.sv
// Extra receive stage: divides incoming enables by N, or bypasses them when N = 0.
// Assumes div stays stable except across a write, which also pulses clr.
module ext_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en_in,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic         bypass;

    // Selects the bypass path or the terminal-count match.
    always_comb begin
        bypass = (div == '0);
        tick   = bypass ? en_in : (en_in && (cnt_q == div - 1'b1));
    end

    // Counts conventional receive enables while the stage is active.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           cnt_q <= '0;
        else if (!bypass && tick)    cnt_q <= '0;
        else if (!bypass && en_in)   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dual_rate_tick_gen.sv
// Top: holds the rate and extra-receive registers and chains the divider stages.
// Assumes one write per cycle. Any write restarts every stage from phase zero.
module dual_rate_tick_gen
    import baudgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic             tx_tick,
    output logic             rx_tick
);
    localparam int PRE_LSB = 2 * EXP_W;
    localparam int NDIR    = 2;

    logic [REG_W-1:0] rate_q;
    logic [REG_W-1:0] ext_q;
    logic             pre_tick;
    logic [NDIR-1:0]  dir_tick;
    logic [EXP_W-1:0] dir_sel [NDIR];

    // Register write port, with both registers reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            ext_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel) ext_q  <= wr_data;
            else        rate_q <= wr_data;
        end
    end

    // Field extraction: index 0 is transmit, index 1 is receive.
    always_comb begin
        dir_sel[0] = rate_q[PRE_LSB-1:EXP_W];
        dir_sel[1] = rate_q[EXP_W-1:0];
    end

    pre_divider u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_en),
        .sel   (rate_q[REG_W-1:PRE_LSB]),
        .tick  (pre_tick)
    );

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        pow2_divider #(.SEL_W(EXP_W)) u_p2 (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (wr_en),
            .en_in (pre_tick),
            .sel   (dir_sel[g]),
            .tick  (dir_tick[g])
        );
    end

    ext_divider #(.W(REG_W)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_en),
        .en_in (dir_tick[1]),
        .div   (ext_q),
        .tick  (rx_tick)
    );

    assign tx_tick = dir_tick[0];
endmodule

// File: rtl/baudgen_checker.sv
// Checker: temporal properties of the tick outputs against the programmed registers.
module baudgen_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] rate_q,
    input logic [7:0] ext_q,
    input logic       tx_tick,
    input logic       rx_tick
);
    logic tx_unit;
    logic rx_unit;
    assign tx_unit = (rate_q[7:3] == 5'd0);
    assign rx_unit = (rate_q[7:6] == 2'd0) && (rate_q[2:0] == 3'd0) && (ext_q <= 8'd1);

    AST_TX_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tick && !wr_en && !tx_unit) |=> !tx_tick); // R7
    AST_RX_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_tick && !wr_en && !rx_unit) |=> !rx_tick); // R7
    AST_TX_UNIT_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_unit |-> tx_tick); // R9
    AST_RX_UNIT_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_unit |-> rx_tick); // R9
    AST_TX_CLEAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !tx_unit) |-> !tx_tick); // R8
    AST_RX_TRACKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q == 8'd0 && rate_q[5:3] == rate_q[2:0]) |-> (rx_tick == tx_tick)); // R5
endmodule

bind dual_rate_tick_gen baudgen_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rate_q  (rate_q),
    .ext_q   (ext_q),
    .tx_tick (tx_tick),
    .rx_tick (rx_tick)
);

// File: tb/tb_dual_rate_tick_gen.sv
module tb_dual_rate_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_tick;
    logic       rx_tick;
    int         checks = 0;
    int         fails  = 0;
    logic [7:0] cur_rate = 8'h00;
    logic [7:0] cur_ext  = 8'h00;

    always #2 clk = ~clk;

    dual_rate_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    function automatic int pfac(input logic [1:0] s);
        case (s)
            2'b00: return 1;
            2'b01: return 3;
            2'b10: return 4;
            default: return 13;
        endcase
    endfunction

    function automatic int tx_period(input logic [7:0] r);
        return pfac(r[7:6]) * (1 << r[5:3]);
    endfunction

    function automatic int rx_period(input logic [7:0] r, input logic [7:0] e);
        return pfac(r[7:6]) * (1 << r[2:0]) * ((e == 0) ? 1 : int'(e));
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Applies one register write. Returns at the negedge inside cycle 0 after the write edge.
    task automatic do_write(input logic sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) cur_ext = data; else cur_rate = data;
    endtask

    // Observes both ticks for three longest periods starting at cycle 0.
    task automatic measure(input string req);
        int dt = tx_period(cur_rate);
        int dr = rx_period(cur_rate, cur_ext);
        int win = 3 * ((dt > dr) ? dt : dr);
        int tfirst = -1, rfirst = -1, tcnt = 0, rcnt = 0;
        for (int k = 0; k < win; k++) begin
            if (tx_tick) begin tcnt++; if (tfirst < 0) tfirst = k; end
            if (rx_tick) begin rcnt++; if (rfirst < 0) rfirst = k; end
            @(negedge clk);
        end
        check(req, "tx first tick", tfirst, dt - 1);
        check(req, "tx tick count", tcnt, win / dt);
        check(req, "rx first tick", rfirst, dr - 1);
        check(req, "rx tick count", rcnt, win / dr);
    endtask

    task automatic t_reset();
        // R6 R9: reset values give a tick on every cycle
        @(negedge clk);
        check("R6", "tx at reset", int'(tx_tick), 1);
        check("R6", "rx at reset", int'(rx_tick), 1);
        measure("R6");
    endtask

    task automatic t_rates();
        do_write(1'b0, 8'b01_010_001); measure("R2");   // R1 R3 R4: 12 and 6
        do_write(1'b0, 8'b11_001_011); measure("R3");   // 26 and 104
        do_write(1'b0, 8'b10_111_000); measure("R4");   // 512 and 4
        do_write(1'b0, 8'b00_101_110); measure("R1");   // 32 and 64
    endtask

    task automatic t_ext();
        do_write(1'b0, 8'b01_010_001);
        do_write(1'b1, 8'd5);   measure("R10");  // R5: tx 12 kept, rx 30
        do_write(1'b0, 8'h00);
        do_write(1'b1, 8'd255); measure("R5");   // tx 1, rx 255
        do_write(1'b1, 8'd0);   measure("R5");   // back to conventional
    endtask

    task automatic t_restart();
        // R8: a rewrite mid-phase restarts from zero
        do_write(1'b0, 8'b00_011_011);
        repeat (5) @(negedge clk);
        do_write(1'b0, 8'b00_011_011);
        measure("R8");
        // R7: widths over a mixed setting
        do_write(1'b0, 8'b01_001_000);
        begin
            int dbl = 0;
            logic prev = 1'b0;
            for (int k = 0; k < 60; k++) begin
                if (tx_tick && prev) dbl++;
                prev = tx_tick;
                @(negedge clk);
            end
            check("R7", "tx back-to-back ticks", dbl, 0);
        end
        do_write(1'b0, 8'h00); measure("R9");
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rates();
        t_ext();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule